// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a general-purpose timer. A free-running count value and an overflow strobe come in from a shared counter outside the block. The channel can be left disconnected. It can capture the count when a chosen edge appears on its input pin. It can compare the count against a stored value and set, clear or toggle its output pin on a match. It can also produce a simple pulse-width-modulated output, where each counter overflow starts a period and the compare match ends the active phase.

Software reaches the channel through a byte-wide bus with separate read and write strobes. Address 0 holds an 8-bit status and control byte. The next addresses hold the bytes of the channel value register, starting with the most significant byte. The status byte carries a sticky event flag that software clears with a read-then-write handshake. A new event that arrives during the handshake cancels the clear, so no interrupt request is lost. The channel raises its interrupt request while the flag and the enable bit are both set.

Top module: `tc_channel`

## Requirements
- R1: After a synchronous reset, every bit of the status/control byte and of the channel value reads 0, and `pin_o` and `irq_o` are 0.
- R2: Status/control bit positions, from bit 7 down to bit 0: event flag, interrupt enable, mode B, mode A, edge/level B, edge/level A, toggle-on-overflow, force-max-duty. Bits 6..0 read back exactly what was last written.
- R3: Mode bits 00 with edge/level bits 01, 10 or 11 select capture on a rising, falling or either edge. Mode 00 with edge/level 00 disconnects the channel, so no pin edge sets the flag. In both cases `pin_o` is held at 0. A pin change is seen on the third rising clock edge after it, because of a two-flop synchronizer and an edge detector.
- R4: On the clock edge where a capture sets the flag, the value on `cnt_i` is loaded into the channel value register. Address 1 reads its high byte and address 2 reads its low byte.
- R5: With mode bits 01 (compare) or 1x (PWM), the flag sets on every clock edge where `cnt_i` equals the channel value.
- R6: In compare mode, a match acts on `pin_o` on the same edge that sets the flag. Edge/level 01 toggles the pin, 10 drives it to 0, 11 drives it to 1, and 00 leaves it unchanged.
- R7: In compare mode with toggle-on-overflow set, `pin_o` toggles on each `ovf_i` pulse. When a match falls in the same cycle, the overflow toggle is applied first and the match action is applied to that result.
- R8: With mode bits 1x (PWM), `ovf_i` drives `pin_o` to the active level and a match drives it to the inactive level. The active level is 0 when edge/level is 11 and 1 otherwise. When a match and an overflow fall in the same cycle, the match wins, which gives 0% duty when the value equals the count at overflow.
- R9: In PWM mode with force-max-duty set, `pin_o` is held at the active level on every clock, whatever the count and the compare value.
- R10: The flag clears only when a write to address 0 with bit 7 = 0 follows a read of address 0 that returned the flag as 1. A write of 0 without such a read leaves the flag unchanged.
- R11: A capture or compare event between the arming read and the clearing write cancels the clear. An event in the same cycle as the clearing write also wins, and the flag stays 1.
- R12: Writing 1 to bit 7 never sets the flag.
- R13: `irq_o` is 1 exactly while the flag and the interrupt enable are both 1.
- R14: Read data appears on `rdata_o` one clock after `rd_en_i`. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W (16) | Shared free-running count |
| ovf_i | input | 1 | One-cycle counter overflow strobe |
| pin_i | input | 1 | Channel input pin (asynchronous) |
| rd_en_i | input | 1 | Bus read strobe |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Bus address: 0 status/control, 1 value high byte, 2 value low byte |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered bus read data |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Channel output pin |

## Verification
The behaviour most at risk is a compare event that lands in the same cycle as the flag-clearing write, or between the arming read and that write. The bench arms the clear with a read, then drives `cnt_i` equal to the channel value in the cycle just before the write, and again in the very cycle the write strobe is high. A correct channel keeps `irq_o` at 1 afterwards. A later, properly armed clear with no match pending must drop it. A second collision is an overflow and a match on the same edge. The bench judges it from the final pin level in compare mode, where toggle, set and clear are combined with the overflow toggle, and in PWM mode, where a zero compare value must give a low output.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;

  localparam int unsigned REG_W = 8;
  localparam int unsigned FLAG_BIT = 7;

  typedef enum logic [1:0] {
    TC_OFF = 2'd0,
    TC_CAP = 2'd1,
    TC_CMP = 2'd2,
    TC_PWM = 2'd3
  } tc_mode_e;

  // Control fields in the bit order of the status byte (bit 6 down to 0)
  typedef struct packed {
    logic       ie;
    logic [1:0] ms;
    logic [1:0] els;
    logic       tov;
    logic       max;
  } tc_cfg_t;

  function automatic tc_mode_e tc_decode(input logic [1:0] ms, input logic [1:0] els);
    if (ms[1]) return TC_PWM;
    if (ms[0]) return TC_CMP;
    if (els != 2'b00) return TC_CAP;
    return TC_OFF;
  endfunction

endpackage

// File: rtl/tc_insync.sv
`timescale 1ns/1ps
module tc_insync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh_q[g] <= 1'b0;
        else     sh_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh_q[g] <= 1'b0;
        else     sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

endmodule

// File: rtl/tc_csr.sv
`timescale 1ns/1ps
module tc_csr
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cap_evt_i,
  input  logic              cmp_en_i,
  output logic [REG_W-1:0]  rdata_o,
  output tc_cfg_t           cfg_o,
  output logic              flag_o,
  output logic              arm_o,
  output logic              evt_o,
  output logic              match_o
);

  localparam int unsigned NB = CNT_W / REG_W;

  logic              flag_q, arm_q;
  tc_cfg_t           cfg_q;
  logic [CNT_W-1:0]  val_w;
  logic [REG_W-1:0]  rd_mux, rdata_q;
  logic              wr_csr, rd_csr;

  assign wr_csr  = wr_en_i && (addr_i == '0);
  assign rd_csr  = rd_en_i && (addr_i == '0);
  assign match_o = cmp_en_i && (cnt_i == val_w);
  assign evt_o   = cap_evt_i | match_o;

  // Value register, one byte slice per generate instance; address 1 = top byte
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [REG_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)                                         byte_q <= '0;
      else if (cap_evt_i)                              byte_q <= cnt_i[g*REG_W +: REG_W];
      else if (wr_en_i && addr_i == ADDR_W'(NB - g))   byte_q <= wdata_i;
    end
    assign val_w[g*REG_W +: REG_W] = byte_q;
  end

  // Control bits
  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (wr_csr) cfg_q <= wdata_i[REG_W-2:0];
  end

  // Sticky flag with arm-then-clear handshake; a new event always wins
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (evt_o) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (wr_csr && !wdata_i[FLAG_BIT] && arm_q) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (rd_csr && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == '0) begin
      rd_mux = {flag_q, cfg_q};
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(NB - b)) rd_mux = val_w[b*REG_W +: REG_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign cfg_o   = cfg_q;
  assign flag_o  = flag_q;
  assign arm_o   = arm_q;

endmodule

// File: rtl/tc_pinout.sv
`timescale 1ns/1ps
module tc_pinout
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  tc_mode_e   mode_i,
  input  logic [1:0] els_i,
  input  logic       tov_i,
  input  logic       max_i,
  input  logic       match_i,
  input  logic       ovf_i,
  output logic       pin_o
);

  logic pin_q, pin_d, act_lvl, tgl;

  assign act_lvl = (els_i != 2'b11);
  assign tgl     = pin_q ^ (tov_i & ovf_i);

  always_comb begin
    pin_d = pin_q;
    case (mode_i)
      TC_CMP: begin
        pin_d = tgl;
        if (match_i) begin
          case (els_i)
            2'b01:   pin_d = ~tgl;
            2'b10:   pin_d = 1'b0;
            2'b11:   pin_d = 1'b1;
            default: pin_d = tgl;
          endcase
        end
      end
      TC_PWM: begin
        if (max_i)        pin_d = act_lvl;
        else if (match_i) pin_d = ~act_lvl;
        else if (ovf_i)   pin_d = act_lvl;
      end
      default: pin_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_d;
  end

  assign pin_o = pin_q;

endmodule

// File: rtl/tc_channel.sv
`timescale 1ns/1ps
module tc_channel
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [CNT_W-1:0]                      cnt_i,
  input  logic                                  ovf_i,
  input  logic                                  pin_i,
  input  logic                                  rd_en_i,
  input  logic                                  wr_en_i,
  input  logic [$clog2(CNT_W/REG_W+1)-1:0]      addr_i,
  input  logic [REG_W-1:0]                      wdata_i,
  output logic [REG_W-1:0]                      rdata_o,
  output logic                                  irq_o,
  output logic                                  pin_o
);

  localparam int unsigned ADDR_W = $clog2(CNT_W / REG_W + 1);

  tc_cfg_t  cfg_w;
  tc_mode_e mode_w;
  logic     rise_w, fall_w, cap_evt_w, cmp_en_w;
  logic     flag_w, arm_w, evt_w, match_w;

  assign mode_w    = tc_decode(cfg_w.ms, cfg_w.els);
  assign cmp_en_w  = (mode_w == TC_CMP) || (mode_w == TC_PWM);
  assign cap_evt_w = (mode_w == TC_CAP) &&
                     ((cfg_w.els[0] && rise_w) || (cfg_w.els[1] && fall_w));

  tc_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  tc_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt_i),
    .cap_evt_i (cap_evt_w),
    .cmp_en_i  (cmp_en_w),
    .rdata_o   (rdata_o),
    .cfg_o     (cfg_w),
    .flag_o    (flag_w),
    .arm_o     (arm_w),
    .evt_o     (evt_w),
    .match_o   (match_w)
  );

  tc_pinout u_pin (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_w),
    .els_i   (cfg_w.els),
    .tov_i   (cfg_w.tov),
    .max_i   (cfg_w.max),
    .match_i (match_w),
    .ovf_i   (ovf_i),
    .pin_o   (pin_o)
  );

  assign irq_o = flag_w & cfg_w.ie;

endmodule

// File: rtl/tc_channel_chk.sv
`timescale 1ns/1ps
module tc_channel_chk
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              rd_en_i,
  input logic                              wr_en_i,
  input logic [$clog2(CNT_W/REG_W+1)-1:0]  addr_i,
  input logic                              wflag_i,
  input logic [REG_W-1:0]                  rdata_o,
  input logic                              pin_o,
  input logic                              irq_o,
  input logic                              flag_w,
  input logic                              arm_w,
  input logic                              evt_w,
  input tc_mode_e                          mode_w,
  input logic [1:0]                        els_w,
  input logic                              max_w
);

  localparam int unsigned NB = CNT_W / REG_W;

  logic wr_csr;
  assign wr_csr = wr_en_i && (addr_i == '0);

  // R12
  flag_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_w && !evt_w && wr_csr && wflag_i) |=> !flag_w);

  // R10
  unarmed_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_w && !arm_w && !evt_w && wr_csr && !wflag_i) |=> flag_w);

  // R11
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    evt_w |=> (flag_w && !arm_w));

  // R13
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(evt_w || wr_csr));

  // R9
  max_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w == TC_PWM && max_w) |=> (pin_o == $past(els_w != 2'b11)));

  // R3
  pin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_w == TC_OFF || mode_w == TC_CAP) |=> !pin_o);

  // R14
  rsv_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (int'(addr_i) > NB)) |=> (rdata_o == '0));

endmodule

bind tc_channel tc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en_i (rd_en_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wflag_i (wdata_i[7]),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .irq_o   (irq_o),
  .flag_w  (flag_w),
  .arm_w   (arm_w),
  .evt_w   (evt_w),
  .mode_w  (mode_w),
  .els_w   (cfg_w.els),
  .max_w   (cfg_w.max)
);

// File: tb/tc_channel_tb_top.sv
`timescale 1ns/1ps
module tc_channel_tb_top;

  localparam int unsigned CNT_W = 16;
  localparam int unsigned AW    = $clog2(CNT_W/8 + 1);
  localparam logic [AW-1:0] A_CSR = 0, A_HI = 1, A_LO = 2, A_RSV = 3;
  localparam logic [15:0]   IDLE  = 16'h7777;

  logic clk = 1'b0, rst = 1'b1;
  logic ovf = 1'b0, pin = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0]    addr  = '0;
  logic [7:0]       wdata = '0;
  logic [CNT_W-1:0] cnt   = IDLE;
  logic [7:0]       rdata;
  logic             irq, pout;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tc_channel #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .cnt_i(cnt), .ovf_i(ovf), .pin_i(pin),
    .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .pin_o(pout)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_val(input logic [15:0] v);
    cpu_wr(A_HI, v[15:8]);
    cpu_wr(A_LO, v[7:0]);
  endtask

  task automatic cnt_pulse(input logic [15:0] c, input logic o);
    @(negedge clk); cnt = c; ovf = o;
    @(negedge clk); cnt = IDLE; ovf = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); pin = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pin", 16'(pout), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    cpu_rd(A_CSR, d); check("R1 csr", 16'(d), 16'h00);
    cpu_rd(A_HI, d);  check("R1 val hi", 16'(d), 16'h00);
    cpu_rd(A_LO, d);  check("R1 val lo", 16'(d), 16'h00);
    cpu_rd(A_RSV, d); check("R14 reserved", 16'(d), 16'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    cpu_wr(A_CSR, 8'h5A); cpu_rd(A_CSR, d); check("R2 readback", 16'(d), 16'h5A);
    cpu_wr(A_CSR, 8'hC3); cpu_rd(A_CSR, d); check("R12 write1 flag", 16'(d), 16'h43);
    check("R13 irq no flag", 16'(irq), 16'h0);
  endtask

  task automatic t_capture();
    logic [7:0] d;
    cpu_wr(A_CSR, 8'h44);
    @(negedge clk); cnt = 16'd100; pin = 1'b1;
    @(negedge clk); check("R3 latency e1", 16'(irq), 16'h0); cnt = 16'd101;
    @(negedge clk); check("R3 latency e2", 16'(irq), 16'h0); cnt = 16'd102;
    @(negedge clk); check("R3 rising edge", 16'(irq), 16'h1); cnt = IDLE;
    cpu_rd(A_HI, d); check("R4 capture hi", 16'(d), 16'h00);
    cpu_rd(A_LO, d); check("R4 capture lo", 16'(d), 16'h66);
    cpu_rd(A_CSR, d); check("R2 flag read", 16'(d), 16'hC4);
    cpu_wr(A_CSR, 8'h44); check("R10 clear", 16'(irq), 16'h0);
    pin_set(1'b0); check("R3 falling ignored", 16'(irq), 16'h0);
    cpu_wr(A_CSR, 8'h48);
    pin_set(1'b1); check("R3 rising ignored", 16'(irq), 16'h0);
    @(negedge clk); cnt = 16'h0ABC;
    pin_set(1'b0); check("R3 falling edge", 16'(irq), 16'h1);
    cnt = IDLE;
    cpu_rd(A_LO, d); check("R4 capture lo2", 16'(d), 16'hBC);
    cpu_rd(A_CSR, d); cpu_wr(A_CSR, 8'h4C);
    pin_set(1'b1); check("R3 any edge rise", 16'(irq), 16'h1);
    cpu_rd(A_CSR, d); cpu_wr(A_CSR, 8'h4C);
    pin_set(1'b0); check("R3 any edge fall", 16'(irq), 16'h1);
    cpu_rd(A_CSR, d); cpu_wr(A_CSR, 8'h40);
    pin_set(1'b1); check("R3 disconnected", 16'(irq), 16'h0);
    pin_set(1'b0); check("R3 pin idle", 16'(pout), 16'h0);
  endtask

  task automatic t_compare();
    logic [7:0] d;
    set_val(16'h1234);
    cpu_wr(A_CSR, 8'h5C);
    cnt_pulse(16'h1233, 1'b0); check("R5 no match", 16'(irq), 16'h0);
    check("R6 no match pin", 16'(pout), 16'h0);
    cnt_pulse(16'h1234, 1'b0); check("R5 match flag", 16'(irq), 16'h1);
    check("R6 set", 16'(pout), 16'h1);
    cpu_wr(A_CSR, 8'h58); check("R10 unarmed write", 16'(irq), 16'h1);
    cnt_pulse(16'h1234, 1'b0); check("R6 clear", 16'(pout), 16'h0);
    cpu_wr(A_CSR, 8'h54);
    cnt_pulse(16'h1234, 1'b0); check("R6 toggle 1", 16'(pout), 16'h1);
    cnt_pulse(16'h1234, 1'b0); check("R6 toggle 2", 16'(pout), 16'h0);
    cpu_rd(A_CSR, d); check("R2 compare csr", 16'(d), 16'hD4);
    cpu_wr(A_CSR, 8'h54); check("R10 armed clear", 16'(irq), 16'h0);
  endtask

  task automatic t_tov();
    logic [7:0] d;
    cpu_wr(A_CSR, 8'h12);
    cnt_pulse(IDLE, 1'b1); check("R7 ovf toggle 1", 16'(pout), 16'h1);
    cnt_pulse(IDLE, 1'b1); check("R7 ovf toggle 2", 16'(pout), 16'h0);
    cpu_wr(A_CSR, 8'h16);
    cnt_pulse(16'h1234, 1'b1); check("R7 toggle+toggle", 16'(pout), 16'h0);
    cpu_wr(A_CSR, 8'h1E);
    cnt_pulse(16'h1234, 1'b1); check("R7 toggle then set", 16'(pout), 16'h1);
    cpu_wr(A_CSR, 8'h1A);
    cnt_pulse(16'h1234, 1'b1); check("R7 toggle then clear", 16'(pout), 16'h0);
    cpu_rd(A_CSR, d); check("R5 flag no ie", 16'(d), 16'h9A);
    cpu_wr(A_CSR, 8'h1A);
    cpu_rd(A_CSR, d); check("R10 cleared", 16'(d), 16'h1A);
  endtask

  task automatic t_pwm();
    set_val(16'h0010);
    cpu_wr(A_CSR, 8'h28);
    cnt_pulse(16'h0000, 1'b1); check("R8 ovf active", 16'(pout), 16'h1);
    cnt_pulse(16'h000F, 1'b0); check("R8 hold", 16'(pout), 16'h1);
    cnt_pulse(16'h0010, 1'b0); check("R8 match inactive", 16'(pout), 16'h0);
    cnt_pulse(16'h0000, 1'b1); check("R8 new period", 16'(pout), 16'h1);
    cpu_wr(A_CSR, 8'h2C);
    cnt_pulse(16'h0000, 1'b1); check("R8 inverted ovf", 16'(pout), 16'h0);
    cnt_pulse(16'h0010, 1'b0); check("R8 inverted match", 16'(pout), 16'h1);
    cpu_wr(A_CSR, 8'h28);
    set_val(16'h0000);
    cnt_pulse(16'h0000, 1'b1); check("R8 zero duty", 16'(pout), 16'h0);
    cnt_pulse(16'h0005, 1'b0); check("R8 zero duty hold", 16'(pout), 16'h0);
    cpu_wr(A_CSR, 8'h29);
    @(negedge clk); check("R9 forced high", 16'(pout), 16'h1);
    cnt_pulse(16'h0000, 1'b0); check("R9 match ignored", 16'(pout), 16'h1);
    cpu_wr(A_CSR, 8'h2D);
    @(negedge clk); check("R9 forced inverted", 16'(pout), 16'h0);
    cpu_wr(A_CSR, 8'h00);
  endtask

  task automatic t_clear_race();
    logic [7:0] d;
    set_val(16'h0050);
    cpu_wr(A_CSR, 8'h50);
    cnt_pulse(16'h0050, 1'b0); check("R13 irq on", 16'(irq), 16'h1);
    cpu_rd(A_CSR, d); check("R2 armed read", 16'(d), 16'hD0);
    cnt_pulse(16'h0050, 1'b0);
    cpu_wr(A_CSR, 8'h50); check("R11 event before write", 16'(irq), 16'h1);
    cpu_wr(A_CSR, 8'h50); check("R10 write w/o rearm", 16'(irq), 16'h1);
    cpu_rd(A_CSR, d);
    @(negedge clk); addr = A_CSR; wdata = 8'h50; wr = 1'b1; cnt = 16'h0050;
    @(negedge clk); wr = 1'b0; cnt = IDLE;
    check("R11 event same cycle", 16'(irq), 16'h1);
    cpu_rd(A_CSR, d);
    cpu_wr(A_CSR, 8'h50); check("R10 final clear", 16'(irq), 16'h0);
    cnt_pulse(16'h0050, 1'b0);
    cpu_wr(A_CSR, 8'h10); check("R13 ie off", 16'(irq), 16'h0);
    cpu_rd(A_CSR, d); check("R13 flag kept", 16'(d), 16'h90);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_capture();
    t_compare();
    t_tov();
    t_pwm();
    t_clear_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule